// File: doc/BRIEF.md
# Status Register and Write-Protect Controller

This block owns the 8-bit status register of a serial EEPROM front end and rules on every write the command decoder asks for. The command decoder hands it one-cycle operation codes (set or clear the write-enable latch, write the status register, write a page) together with the data collected for them. The block then either drops the request or starts a self-timed internal write cycle. During that cycle it raises a busy flag. When the timer runs out, it updates the status bits or plays the buffered page out to the memory array one byte per clock.

Three mechanisms gate writes. A write-enable latch must be set before any write and clears itself after each completed one. A 2-bit block-protect field guards none, the top quarter, the top half or all of the array. A hardware guard, made of the active-low protect pin and a nonvolatile enable bit, blocks status-register writes only. The enable bit and the block-protect field are nonvolatile: they hold their value through `rst_n`. Only the latch and the cycle state are cleared by it. The cycle length is a parameter counted in clocks, and its default gives 5 ms at 200 MHz.

Top module: `wp_status_ctrl`

## Requirements
- R1: `status_o` is laid out as bit 7 protect-enable, bits 6..4 zero, bits 3..2 block-protect (bit 3 the upper), bit 1 write-enable latch, bit 0 busy; `busy_o` equals bit 0.
- R2: While `rst_n` is low and after it rises, the latch and busy bits are 0 and no array strobe is issued. The protect-enable and block-protect bits keep the value they had before the reset.
- R3: When idle, op 1 sets the latch and op 2 clears it, with effect in the next cycle, whatever the protection state and the pin.
- R4: With the latch at 0, op 3 (status write) and op 4 (page write) are dropped: no cycle starts and the status is unchanged.
- R5: Block-protect 00 guards nothing, 01 guards addresses 0x300..0x3FF, 10 guards 0x200..0x3FF, 11 guards all. A page write whose page lies in a guarded range is dropped whole, with no cycle and the latch left at 1.
- R6: When `wp_n` is 0 and protect-enable is 1, a status write is dropped, but page writes to unguarded blocks still run. With protect-enable at 0, `wp_n` has no effect.
- R7: An accepted request raises busy in the next cycle. Busy then stays high for `CYCLE_CLKS` cycles (status write) or `CYCLE_CLKS + length` cycles (page write), and the latch reads 0 from the cycle busy falls.
- R8: A status write changes only bits 7, 3 and 2, taking them from `sr_wdata_i[7]`, `[3]` and `[2]`. The new value appears in the same cycle that busy falls.
- R9: A page write of length L starting at address A issues L strobes in the last L busy cycles. Strobe i carries byte i (`pg_data_i[8i+7:8i]`) to the address whose page is that of A and whose low 4 bits are (A + i) mod 16, so a write wraps within its page.
- R10: Every request arriving while busy is ignored, and a change on `wp_n` after a cycle has started does not alter that cycle.
- R11: A page write with length 0 or above 16 is dropped with no cycle and no latch change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low soft reset (volatile state only) |
| cmd_op_i | input | 3 | One-cycle request: 0 none, 1 set latch, 2 clear latch, 3 status write, 4 page write |
| sr_wdata_i | input | 8 | Byte for a status write |
| pg_addr_i | input | 10 | Start address of a page write |
| pg_len_i | input | 5 | Number of bytes in a page write |
| pg_data_i | input | 128 | Page bytes, byte i at bits 8i+7..8i |
| wp_n | input | 1 | Active-low hardware protect pin |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Internal write cycle in progress |
| mem_we_o | output | 1 | Array byte write strobe |
| mem_addr_o | output | 10 | Array byte address |
| mem_wdata_o | output | 8 | Array byte data |

## Verification
On every cycle, the assertions check four things. A strobe only occurs inside a busy window, and no strobe ever lands in a range guarded by the current block-protect field. Busy rises only with the latch set and falls with the latch cleared. The nonvolatile bits never move while a cycle is running. Only the bench's scenarios can show the rest: which requests are dropped under each combination of latch, pin and protect bits; the exact busy lengths; the byte-to-address mapping with in-page wrap; that busy-time requests and pin changes leave the outcome unchanged; and that the nonvolatile bits survive a soft reset.

// File: rtl/wpc_pkg.sv
package wpc_pkg;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_LATCH_SET = 3'd1,
        OP_LATCH_CLR = 3'd2,
        OP_SR_WRITE  = 3'd3,
        OP_PG_WRITE  = 3'd4
    } wpc_op_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TIMING = 2'd1,
        PH_COMMIT = 2'd2
    } wpc_phase_e;

    // status byte bit positions
    localparam int SR_WIP_BIT  = 0;
    localparam int SR_WEL_BIT  = 1;
    localparam int SR_BP_LO    = 2;
    localparam int SR_BP_HI    = 3;
    localparam int SR_WPEN_BIT = 7;

endpackage

// File: rtl/wpc_blk_protect.sv
module wpc_blk_protect #(
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        bp_i,
    output logic              guarded_o
);
    logic [1:0] quarter;

    always_comb begin
        quarter = addr_i[ADDR_W-1 -: 2];
        unique case (bp_i)
            2'b00:   guarded_o = 1'b0;
            2'b01:   guarded_o = (quarter == 2'b11);
            2'b10:   guarded_o = quarter[1];
            default: guarded_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpc_access_check.sv
module wpc_access_check
    import wpc_pkg::*;
(
    input  logic    busy_i,
    input  wpc_op_e op_i,
    input  logic    wel_i,
    input  logic    wpen_i,
    input  logic    wp_n_i,
    input  logic    pg_guarded_i,
    input  logic    pg_len_ok_i,
    output logic    latch_set_o,
    output logic    latch_clr_o,
    output logic    go_status_o,
    output logic    go_page_o
);
    logic hw_lock;

    always_comb begin
        hw_lock     = wpen_i & ~wp_n_i;
        latch_set_o = ~busy_i & (op_i == OP_LATCH_SET);
        latch_clr_o = ~busy_i & (op_i == OP_LATCH_CLR);
        go_status_o = ~busy_i & (op_i == OP_SR_WRITE) & wel_i & ~hw_lock;
        go_page_o   = ~busy_i & (op_i == OP_PG_WRITE) & wel_i
                      & ~pg_guarded_i & pg_len_ok_i;
    end
endmodule

// File: rtl/wpc_cycle_timer.sv
module wpc_cycle_timer #(
    parameter int CYCLE_CLKS = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(CYCLE_CLKS + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d     = tmr_q;
        expired_o = tmr_q.run && (tmr_q.cnt == CNT_W'(CYCLE_CLKS - 1));
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (expired_o) begin
            tmr_d.run = 1'b0;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/wpc_page_buf.sv
module wpc_page_buf #(
    parameter int PAGE_BYTES = 16
) (
    input  logic                          clk,
    input  logic                          load_i,
    input  logic [8*PAGE_BYTES-1:0]       wdata_i,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
    output logic [7:0]                    rd_byte_o
);
    logic [7:0] byte_d [PAGE_BYTES];
    logic [7:0] byte_q [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_byte
        always_comb byte_d[g] = load_i ? wdata_i[8*g +: 8] : byte_q[g];
        always_ff @(posedge clk) byte_q[g] <= byte_d[g];
    end

    always_comb rd_byte_o = byte_q[rd_idx_i];
endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl
    import wpc_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int PAGE_BYTES = 16,
    parameter int CYCLE_CLKS = 1000000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2:0]                      cmd_op_i,
    input  logic [7:0]                      sr_wdata_i,
    input  logic [ADDR_W-1:0]               pg_addr_i,
    input  logic [$clog2(PAGE_BYTES):0]     pg_len_i,
    input  logic [8*PAGE_BYTES-1:0]         pg_data_i,
    input  logic                            wp_n,
    output logic [7:0]                      status_o,
    output logic                            busy_o,
    output logic                            mem_we_o,
    output logic [ADDR_W-1:0]               mem_addr_o,
    output logic [7:0]                      mem_wdata_o
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int LEN_W  = OFF_W + 1;
    localparam int BASE_W = ADDR_W - OFF_W;

    typedef struct packed {
        wpc_phase_e        phase;
        logic              wel;
        logic              is_page;
        logic [2:0]        sr_pend;   // {wpen, bp[1:0]} waiting for cycle end
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  start;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  idx;
    } vol_t;

    typedef struct packed {
        logic       wpen;
        logic [1:0] bp;
    } nv_t;

    vol_t vol_d, vol_q;
    nv_t  nv_d,  nv_q;

    wpc_op_e         op;
    logic            busy;
    logic            pg_guarded;
    logic            pg_len_ok;
    logic            latch_set, latch_clr, go_status, go_page;
    logic            tmr_expired;
    logic [OFF_W-1:0] rd_idx;
    logic [OFF_W-1:0] wr_off;
    logic [7:0]      rd_byte;

    wire unused_sr_bits = ^{sr_wdata_i[6:4], sr_wdata_i[1:0]};

    always_comb begin
        op        = wpc_op_e'(cmd_op_i);
        busy      = (vol_q.phase != PH_IDLE);
        pg_len_ok = (pg_len_i != '0) && (pg_len_i <= LEN_W'(PAGE_BYTES));
    end

    wpc_blk_protect #(.ADDR_W(ADDR_W)) u_prot (
        .addr_i    (pg_addr_i),
        .bp_i      (nv_q.bp),
        .guarded_o (pg_guarded)
    );

    wpc_access_check u_check (
        .busy_i       (busy),
        .op_i         (op),
        .wel_i        (vol_q.wel),
        .wpen_i       (nv_q.wpen),
        .wp_n_i       (wp_n),
        .pg_guarded_i (pg_guarded),
        .pg_len_ok_i  (pg_len_ok),
        .latch_set_o  (latch_set),
        .latch_clr_o  (latch_clr),
        .go_status_o  (go_status),
        .go_page_o    (go_page)
    );

    wpc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (go_status | go_page),
        .expired_o (tmr_expired)
    );

    wpc_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .load_i    (go_page),
        .wdata_i   (pg_data_i),
        .rd_idx_i  (rd_idx),
        .rd_byte_o (rd_byte)
    );

    // next-state logic
    always_comb begin
        vol_d = vol_q;
        nv_d  = nv_q;
        unique case (vol_q.phase)
            PH_IDLE: begin
                if (latch_set) vol_d.wel = 1'b1;
                if (latch_clr) vol_d.wel = 1'b0;
                if (go_status || go_page) begin
                    vol_d.phase   = PH_TIMING;
                    vol_d.is_page = go_page;
                    vol_d.sr_pend = {sr_wdata_i[SR_WPEN_BIT],
                                     sr_wdata_i[SR_BP_HI], sr_wdata_i[SR_BP_LO]};
                    vol_d.base    = pg_addr_i[ADDR_W-1:OFF_W];
                    vol_d.start   = pg_addr_i[OFF_W-1:0];
                    vol_d.len     = pg_len_i;
                    vol_d.idx     = '0;
                end
            end
            PH_TIMING: begin
                if (tmr_expired) begin
                    if (vol_q.is_page) begin
                        vol_d.phase = PH_COMMIT;
                        vol_d.idx   = '0;
                    end else begin
                        vol_d.phase = PH_IDLE;
                        vol_d.wel   = 1'b0;
                        nv_d.wpen   = vol_q.sr_pend[2];
                        nv_d.bp     = vol_q.sr_pend[1:0];
                    end
                end
            end
            PH_COMMIT: begin
                if (vol_q.idx == vol_q.len - 1'b1) begin
                    vol_d.phase = PH_IDLE;
                    vol_d.wel   = 1'b0;
                end else begin
                    vol_d.idx = vol_q.idx + 1'b1;
                end
            end
            default: vol_d.phase = PH_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        rd_idx      = vol_q.idx[OFF_W-1:0];
        wr_off      = vol_q.start + rd_idx;
        mem_we_o    = (vol_q.phase == PH_COMMIT);
        mem_addr_o  = {vol_q.base, wr_off};
        mem_wdata_o = rd_byte;
        busy_o      = busy;
        status_o    = '0;
        status_o[SR_WPEN_BIT]         = nv_q.wpen;
        status_o[SR_BP_HI:SR_BP_LO]   = nv_q.bp;
        status_o[SR_WEL_BIT]          = vol_q.wel;
        status_o[SR_WIP_BIT]          = busy;
    end

    // volatile state: cleared by soft reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q <= '0;
        else        vol_q <= vol_d;
    end

    // nonvolatile bits: no reset, hold across rst_n
    always_ff @(posedge clk) begin
        if (!rst_n) nv_q <= nv_q;
        else        nv_q <= nv_d;
    end
endmodule

// File: rtl/wpc_checks.sv
module wpc_checks #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        status_o,
    input logic              busy_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    wire unused_status_bits = ^status_o[6:4];

    logic [1:0] bp;
    logic       in_guard;

    always_comb begin
        bp       = status_o[3:2];
        in_guard = (bp == 2'b11)
                || (bp == 2'b10 && int'(mem_addr_o) >= (2 << (ADDR_W - 2)))
                || (bp == 2'b01 && int'(mem_addr_o) >= (3 << (ADDR_W - 2)));
    end

    p_strobe_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    p_no_guarded_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> !in_guard);

    p_start_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> status_o[1]);

    p_end_clears_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !status_o[1]);

    p_nv_frozen_in_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable({status_o[7], status_o[3:2]}));
endmodule

bind wp_status_ctrl wpc_checks #(.ADDR_W(ADDR_W)) u_wpc_checks (
    .clk        (clk),
    .rst_n      (rst_n),
    .status_o   (status_o),
    .busy_o     (busy_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/wp_status_ctrl_bench.sv
`timescale 1ns/1ps
module wp_status_ctrl_bench;
    localparam int CYC = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   cmd_op = 3'd0;
    logic [7:0]   sr_wdata = 8'd0;
    logic [9:0]   pg_addr = 10'd0;
    logic [4:0]   pg_len = 5'd0;
    logic [127:0] pg_data = '0;
    logic         wp_n = 1'b1;
    logic [7:0]   status_o;
    logic         busy_o;
    logic         mem_we_o;
    logic [9:0]   mem_addr_o;
    logic [7:0]   mem_wdata_o;

    always #2.5 clk = ~clk;

    wp_status_ctrl #(.CYCLE_CLKS(CYC)) u_wp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_op_i(cmd_op), .sr_wdata_i(sr_wdata),
        .pg_addr_i(pg_addr), .pg_len_i(pg_len), .pg_data_i(pg_data), .wp_n(wp_n),
        .status_o(status_o), .busy_o(busy_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit cmp_on = 0, done = 0;
    logic [7:0] tb_mem [1024];

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // behavioural reference model
    int m_wel = 0, m_phase = 0, m_cnt = 0, m_idx = 0, m_len = 0;
    int m_wpen = 0, m_bp = 0, m_pwpen = 0, m_pbp = 0, m_pg = 0;
    int m_base = 0, m_start = 0;
    int m_buf [16];

    function automatic int guarded(input int a, input int bp);
        case (bp)
            1: return (a >= 'h300) ? 1 : 0;
            2: return (a >= 'h200) ? 1 : 0;
            3: return 1;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_wel = 0; m_phase = 0; m_cnt = 0; m_idx = 0;
        end else begin
            case (m_phase)
                0: case (int'(cmd_op))
                    1: m_wel = 1;
                    2: m_wel = 0;
                    3: if (m_wel == 1 && !(m_wpen == 1 && wp_n == 1'b0)) begin
                        m_phase = 1; m_cnt = 0; m_pg = 0;
                        m_pwpen = int'(sr_wdata[7]); m_pbp = int'(sr_wdata[3:2]);
                    end
                    4: if (m_wel == 1 && guarded(int'(pg_addr), m_bp) == 0
                           && pg_len >= 1 && pg_len <= 16) begin
                        m_phase = 1; m_cnt = 0; m_pg = 1;
                        m_base = int'(pg_addr) / 16 * 16;
                        m_start = int'(pg_addr) % 16;
                        m_len = int'(pg_len);
                        for (int i = 0; i < 16; i++) m_buf[i] = int'(pg_data[8*i +: 8]);
                    end
                    default: ;
                endcase
                1: if (m_cnt == CYC - 1) begin
                    if (m_pg == 1) begin
                        m_phase = 2; m_idx = 0;
                    end else begin
                        m_phase = 0; m_wel = 0; m_wpen = m_pwpen; m_bp = m_pbp;
                    end
                end else m_cnt++;
                default: if (m_idx == m_len - 1) begin
                    m_phase = 0; m_wel = 0;
                end else m_idx++;
            endcase
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_on && !done) begin
            check("R1/R7 status", int'(status_o),
                  m_wpen * 128 + m_bp * 4 + m_wel * 2 + ((m_phase != 0) ? 1 : 0));
            check("R1 busy", int'(busy_o), (m_phase != 0) ? 1 : 0);
            check("R9 strobe", int'(mem_we_o), (m_phase == 2) ? 1 : 0);
            if (m_phase == 2) begin
                check("R9 addr", int'(mem_addr_o), m_base + (m_start + m_idx) % 16);
                check("R9 data", int'(mem_wdata_o), m_buf[m_idx]);
            end
            if (mem_we_o) tb_mem[mem_addr_o] = mem_wdata_o;
        end
    end

    function automatic logic [127:0] mk(input int seed);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[8*i +: 8] = 8'(seed + i);
        return r;
    endfunction

    task automatic issue(input int o, input int sd, input int a, input int l, input int seed);
        @(negedge clk);
        cmd_op = 3'(o); sr_wdata = 8'(sd); pg_addr = 10'(a);
        pg_len = 5'(l); pg_data = mk(seed);
        @(negedge clk);
        cmd_op = 3'd0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    initial begin
        int n;
        for (int i = 0; i < 1024; i++) tb_mem[i] = 8'hEE;
        repeat (4) @(negedge clk);
        check("R2 reset latch/busy", int'(status_o & 8'h03), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 volatile after reset", int'(status_o & 8'h73), 0);
        m_wpen = int'(status_o[7]); m_bp = int'(status_o[3:2]);
        cmp_on = 1;

        // R3: latch control
        issue(1, 0, 0, 0, 0);
        check("R3 set latch", int'(status_o[1]), 1);
        issue(3, 'h00, 0, 0, 0); wait_idle(n);
        check("R8 clear nv", int'(status_o), 'h00);
        issue(1, 0, 0, 0, 0);
        issue(2, 0, 0, 0, 0);
        check("R3 clear latch", int'(status_o[1]), 0);

        // R4: latch off blocks writes
        issue(4, 0, 'h100, 1, 'h11);
        check("R4 page write dropped", int'(busy_o), 0);
        issue(3, 'h8C, 0, 0, 0);
        check("R4 status write dropped", int'(status_o), 'h00);

        // R7/R9: page write with wrap
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h10E, 4, 'h40); wait_idle(n);
        check("R7 page busy length", n, CYC + 4);
        check("R7 latch cleared", int'(status_o), 'h00);
        check("R9 byte0", int'(tb_mem['h10E]), 'h40);
        check("R9 byte1", int'(tb_mem['h10F]), 'h41);
        check("R9 wrap byte2", int'(tb_mem['h100]), 'h42);
        check("R9 wrap byte3", int'(tb_mem['h101]), 'h43);
        check("R9 untouched", int'(tb_mem['h102]), 'hEE);

        // R8/R1: status write keeps only bits 7,3,2
        issue(1, 0, 0, 0, 0);
        issue(3, 'hFF, 0, 0, 0); wait_idle(n);
        check("R7 status busy length", n, CYC);
        check("R8 R1 status value", int'(status_o), 'h8C);

        // R5: all guarded
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h000, 1, 0);
        check("R5 guarded page dropped", int'(status_o), 'h8E);

        // R6: hardware lock
        wp_n = 1'b0;
        issue(3, 'h04, 0, 0, 0);
        check("R6 status write locked", int'(status_o), 'h8E);
        issue(2, 0, 0, 0, 0);
        check("R3 clear under lock", int'(status_o), 'h8C);
        issue(1, 0, 0, 0, 0);
        check("R3 set under lock", int'(status_o), 'h8E);
        wp_n = 1'b1;
        issue(3, 'h84, 0, 0, 0); wait_idle(n);
        check("R6 pin high allows", int'(status_o), 'h84);
        wp_n = 1'b0;
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h2F0, 2, 'h10);
        check("R6 unguarded block writable", int'(busy_o), 1);
        wait_idle(n);
        check("R9 data at 0x2F0", int'(tb_mem['h2F0]), 'h10);
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h300, 1, 0);
        check("R5 quarter guard", int'(busy_o), 0);
        issue(4, 0, 'h3F8, 16, 0);
        check("R5 quarter guard top", int'(status_o), 'h86);

        wp_n = 1'b1;
        issue(3, 'h08, 0, 0, 0); wait_idle(n);
        check("R8 half guard set", int'(status_o), 'h08);
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h200, 1, 0);
        check("R5 half guard", int'(busy_o), 0);
        issue(4, 0, 'h1F0, 1, 'h22);
        check("R5 below half writable", int'(busy_o), 1);
        wait_idle(n);
        wp_n = 1'b0;
        issue(1, 0, 0, 0, 0);
        issue(3, 'h00, 0, 0, 0);
        check("R6 pin ignored when enable off", int'(busy_o), 1);
        wait_idle(n);
        check("R6 status cleared", int'(status_o), 'h00);

        // R10: requests during a cycle
        issue(1, 0, 0, 0, 0);
        issue(3, 'h80, 0, 0, 0);
        issue(2, 0, 0, 0, 0);
        check("R10 clear ignored when busy", int'(status_o), 'h03);
        issue(4, 0, 'h0A0, 1, 'h55);
        wait_idle(n);
        check("R10 status result", int'(status_o), 'h80);
        check("R10 page ignored", int'(tb_mem['h0A0]), 'hEE);
        wp_n = 1'b1;
        issue(1, 0, 0, 0, 0);
        issue(3, 'h8C, 0, 0, 0);
        wp_n = 1'b0;
        wait_idle(n);
        check("R10 pin change mid cycle", int'(status_o), 'h8C);

        // R11: length limits
        wp_n = 1'b1;
        issue(1, 0, 0, 0, 0);
        issue(3, 'h00, 0, 0, 0); wait_idle(n);
        issue(1, 0, 0, 0, 0);
        issue(4, 0, 'h050, 0, 0);
        check("R11 zero length", int'(status_o), 'h02);
        issue(4, 0, 'h050, 17, 0);
        check("R11 over length", int'(status_o), 'h02);
        issue(4, 0, 'h055, 16, 'h70); wait_idle(n);
        check("R7 full page length", n, CYC + 16);
        check("R9 full page first", int'(tb_mem['h055]), 'h70);
        check("R9 full page last wraps", int'(tb_mem['h054]), 'h7F);

        // R2: soft reset keeps nonvolatile bits
        issue(1, 0, 0, 0, 0);
        issue(3, 'h88, 0, 0, 0); wait_idle(n);
        issue(1, 0, 0, 0, 0);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 during reset", int'(status_o), 'h88);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 nv retained", int'(status_o), 'h88);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule